// File: doc/BRIEF.md
# Interrupt Dispatch Sequencer

This block runs the hardware call that an 8-bit processor core makes when it accepts an interrupt, and the matching return. When the core signals that an instruction has finished, an interrupt request is present and the global enable (bit 0 of the flag register) is set, the sequencer takes over for a fixed 13 cycles. In that time it saves the 16-bit program counter and the flags on a byte-wide stack, clears the flags, acknowledges the controller and loads the program counter with the vector: zero in the high byte and the controller's byte in the low byte. Normal fetching resumes at that address once the sequence ends.

The return path runs when the core reports a return-from-interrupt instruction at a boundary. It pops the flags, the low PC byte and the high PC byte, so that the saved enable state comes back with the flags. If an enabled request is waiting when the return ends, the next dispatch follows at once, with no normal instruction in between. The program counter, flag register and stack pointer live inside the block. The core may load the PC and the flags only while the sequencer is idle.

The sequencer is one state machine with three states: `ST_IDLE`, `ST_DISP` (dispatch, 13 steps) and `ST_RET` (return, 8 steps). A step counter orders the work inside each state. Its transitions are:
- `ST_IDLE` to `ST_DISP` on take_irq: a boundary strobe while a request is present and the enable is set.
- `ST_IDLE` to `ST_RET` on take_ret: a boundary strobe with a return request and no take_irq.
- `ST_DISP` advances one step per cycle and returns to `ST_IDLE` after its last step.
- `ST_RET` advances one step per cycle. After its last step it goes to `ST_DISP` on chain (a request is present and the restored enable is set), and otherwise to `ST_IDLE`.

Top module: `irq_dispatch_seq`

## Requirements
- R1: A dispatch starts only at a clock edge where the block is idle, `insn_done`=1, `irq_req`=1 and `flags[0]`=1. `busy` goes high in the following cycle. A request without the boundary strobe, or with `flags[0]`=0, leaves `busy` low.
- R2: A dispatch keeps `busy` high for exactly 13 cycles, and `done` is high only in the 13th of them.
- R3: A dispatch makes three stack writes in successive cycles, at addresses `sp`, `sp`+1 and `sp`+2, with data PC[15:8], PC[7:0] and the flags in that order. `sp` ends 3 higher than it started.
- R4: The flag register is 0x00 after the pushes and stays 0x00 after the dispatch.
- R5: `irq_ack` pulses for exactly one cycle per dispatch. After the dispatch the PC equals {0x00, the `irq_vec` value present in the cycle `irq_ack` is high}.
- R6: At a boundary with `reti_req`=1 and no dispatch taken, the return reads the stack at `sp`-1, `sp`-2 and `sp`-3 into the flags, PC[7:0] and PC[15:8]. `sp` ends 3 lower. `busy` is high for 8 cycles with `done` in the last, and there are no stack writes.
- R7: If `irq_req`=1 and the restored `flags[0]`=1 in the last return cycle, a dispatch begins in the next cycle without a boundary strobe. `busy` then stays high for 8+13 cycles.
- R8: The core writes `core_pc_we`/`core_pc_d` and `core_flg_we`/`core_flg_d` take effect at the next edge while idle, and are ignored while `busy` is high.
- R9: When `irq_req` (with `flags[0]`=1) and `reti_req` arrive at the same boundary, the dispatch is taken and the return is not.
- R10: After reset the PC, flags and `sp` are zero and `busy` is low. `stk_we` is never high outside the push cycles of a dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| reti_req | input | 1 | The finishing instruction is a return-from-interrupt |
| irq_req | input | 1 | Interrupt request from the controller |
| irq_vec | input | 8 | Vector low byte from the controller |
| irq_ack | output | 1 | Vector taken, one-cycle pulse |
| core_pc_we | input | 1 | Core load of the PC |
| core_pc_d | input | 16 | Core PC value |
| core_flg_we | input | 1 | Core load of the flags |
| core_flg_d | input | 8 | Core flag value |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | 8 | Stack address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, combinational from `stk_addr` |
| sp | output | 8 | Stack pointer |
| pc | output | 16 | Program counter |
| flags | output | 8 | Flag register, bit 0 is the global enable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | Last cycle of a sequence |

## Verification
The following are checked on every cycle:
- The stack pointer moves by exactly one on every push and every pop.
- Nothing is written to the stack while idle.
- The flags are zero when the acknowledge fires.
- The PC takes {0x00, vector} right after the acknowledge.
- The PC stays unchanged through busy cycles that do not load it.
- Dispatch has priority over return, and chaining starts with the high-byte push.

Some properties can only be shown by the bench's scenarios:
- The exact 13-cycle and 21-cycle busy windows.
- The order of the pushed bytes when the stack pointer is non-zero and when interrupts are nested.
- The restore of the saved enable bit, and whether a chained dispatch follows.

// File: rtl/ids_pkg.sv
package ids_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISP,
        ST_RET
    } ids_state_e;

    typedef enum logic [1:0] {
        SEL_PCH,
        SEL_PCL,
        SEL_FLG,
        SEL_NONE
    } ids_sel_e;

    // step numbers inside a dispatch
    localparam int STEP_PUSH_H = 0;
    localparam int STEP_PUSH_L = 1;
    localparam int STEP_PUSH_F = 2;
    localparam int STEP_CLEAR  = 3;
    localparam int STEP_VECTOR = 4;

    // step numbers inside a return
    localparam int STEP_POP_F = 0;
    localparam int STEP_POP_L = 1;
    localparam int STEP_POP_H = 2;

endpackage

// File: rtl/ids_fsm.sv
module ids_fsm
    import ids_pkg::*;
#(
    parameter int DISP_CYCLES = 13,
    parameter int RET_CYCLES  = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     insn_done,
    input  logic     irq_req,
    input  logic     reti_req,
    input  logic     gie,
    output logic     busy,
    output logic     done,
    output logic     push_en,
    output ids_sel_e push_sel,
    output logic     clr_flags,
    output logic     vec_load,
    output logic     pop_en,
    output ids_sel_e pop_sel
);

    localparam int MAX_CYC = (DISP_CYCLES > RET_CYCLES) ? DISP_CYCLES : RET_CYCLES;
    localparam int CW      = $clog2(MAX_CYC);
    localparam logic [CW-1:0] DISP_LAST = CW'(DISP_CYCLES - 1);
    localparam logic [CW-1:0] RET_LAST  = CW'(RET_CYCLES - 1);

    ids_state_e    state_q, state_d;
    logic [CW-1:0] step_q, step_d;
    logic          take_irq, take_ret;

    assign take_irq = insn_done && irq_req && gie;
    assign take_ret = insn_done && reti_req && !take_irq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_irq) begin
                    state_d = ST_DISP;
                    step_d  = '0;
                end else if (take_ret) begin
                    state_d = ST_RET;
                    step_d  = '0;
                end
            end
            ST_DISP: begin
                if (step_q == DISP_LAST) begin
                    state_d = ST_IDLE;
                    step_d  = '0;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            ST_RET: begin
                if (step_q == RET_LAST) begin
                    state_d = (irq_req && gie) ? ST_DISP : ST_IDLE;
                    step_d  = '0;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                step_d  = '0;
            end
        endcase
    end

    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        push_en   = 1'b0;
        push_sel  = SEL_NONE;
        clr_flags = 1'b0;
        vec_load  = 1'b0;
        pop_en    = 1'b0;
        pop_sel   = SEL_NONE;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_DISP: begin
                busy = 1'b1;
                done = (step_q == DISP_LAST);
                if (step_q == CW'(STEP_PUSH_H)) begin
                    push_en  = 1'b1;
                    push_sel = SEL_PCH;
                end else if (step_q == CW'(STEP_PUSH_L)) begin
                    push_en  = 1'b1;
                    push_sel = SEL_PCL;
                end else if (step_q == CW'(STEP_PUSH_F)) begin
                    push_en  = 1'b1;
                    push_sel = SEL_FLG;
                end else if (step_q == CW'(STEP_CLEAR)) begin
                    clr_flags = 1'b1;
                end else if (step_q == CW'(STEP_VECTOR)) begin
                    vec_load = 1'b1;
                end
            end
            ST_RET: begin
                busy = 1'b1;
                done = (step_q == RET_LAST);
                if (step_q == CW'(STEP_POP_F)) begin
                    pop_en  = 1'b1;
                    pop_sel = SEL_FLG;
                end else if (step_q == CW'(STEP_POP_L)) begin
                    pop_en  = 1'b1;
                    pop_sel = SEL_PCL;
                end else if (step_q == CW'(STEP_POP_H)) begin
                    pop_en  = 1'b1;
                    pop_sel = SEL_PCH;
                end
            end
            default: begin
            end
        endcase
    end

    // R1: a sequence only begins after a boundary strobe
    a_r1_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(insn_done));

    // R2: the dispatch is followed by an idle cycle
    a_r2_idle_after_disp: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state_q == ST_DISP) |=> !busy);

    // R5: a single acknowledge per dispatch
    a_r5_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_load |=> !vec_load);

    // R9: a dispatch wins over a return at the same boundary
    a_r9_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && insn_done && irq_req && gie && reti_req)
            |=> (push_en && push_sel == SEL_PCH));

    // R7: a waiting enabled request chains straight after the return
    a_r7_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET && done && irq_req && gie) |=> (push_en && push_sel == SEL_PCH));

endmodule

// File: rtl/ids_regs.sv
module ids_regs
    import ids_pkg::*;
#(
    parameter int SP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  logic            push_en,
    input  ids_sel_e        push_sel,
    input  logic            pop_en,
    input  ids_sel_e        pop_sel,
    input  logic            clr_flags,
    input  logic            vec_load,
    input  logic [7:0]      irq_vec,
    input  logic            core_pc_we,
    input  logic [15:0]     core_pc_d,
    input  logic            core_flg_we,
    input  logic [7:0]      core_flg_d,
    input  logic [7:0]      stk_rdata,
    output logic            stk_we,
    output logic [SP_W-1:0] stk_addr,
    output logic [7:0]      stk_wdata,
    output logic [SP_W-1:0] sp,
    output logic [15:0]     pc,
    output logic [7:0]      flags
);

    localparam int PC_BYTES = 2;

    logic [SP_W-1:0] sp_q;
    logic [7:0]      flg_q;
    logic            core_ok;

    assign core_ok = !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (push_en) begin
            sp_q <= sp_q + SP_W'(1);
        end else if (pop_en) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= 8'h00;
        end else if (pop_en && pop_sel == SEL_FLG) begin
            flg_q <= stk_rdata;
        end else if (clr_flags) begin
            flg_q <= 8'h00;
        end else if (core_ok && core_flg_we) begin
            flg_q <= core_flg_d;
        end
    end

    for (genvar g = 0; g < PC_BYTES; g++) begin : g_lane
        localparam ids_sel_e LANE_SEL = (g == 1) ? SEL_PCH : SEL_PCL;
        localparam bit       IS_LOW   = (g == 0);
        logic [7:0] lane_q;
        logic [7:0] vec_byte;

        assign vec_byte = IS_LOW ? irq_vec : 8'h00;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_q <= 8'h00;
            end else if (pop_en && pop_sel == LANE_SEL) begin
                lane_q <= stk_rdata;
            end else if (vec_load) begin
                lane_q <= vec_byte;
            end else if (core_ok && core_pc_we) begin
                lane_q <= core_pc_d[g*8 +: 8];
            end
        end

        assign pc[g*8 +: 8] = lane_q;
    end

    always_comb begin
        unique case (push_sel)
            SEL_PCH: stk_wdata = pc[15:8];
            SEL_PCL: stk_wdata = pc[7:0];
            SEL_FLG: stk_wdata = flg_q;
            default: stk_wdata = 8'h00;
        endcase
    end

    assign stk_we   = push_en;
    assign stk_addr = pop_en ? (sp_q - SP_W'(1)) : sp_q;
    assign sp       = sp_q;
    assign flags    = flg_q;

    // R3: each push moves the pointer up by one
    a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> sp == $past(sp) + SP_W'(1));

    // R6: each pop moves the pointer down by one
    a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |=> sp == $past(sp) - SP_W'(1));

    // R10: no stack writes while idle
    a_r10_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !stk_we);

    // R8: core loads do not reach the PC while a sequence runs
    a_r8_pc_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pop_en && !vec_load) |=> pc == $past(pc));

endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
    import ids_pkg::*;
#(
    parameter int DISP_CYCLES = 13,
    parameter int RET_CYCLES  = 8,
    parameter int SP_W        = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_done,
    input  logic            reti_req,
    input  logic            irq_req,
    input  logic [7:0]      irq_vec,
    output logic            irq_ack,
    input  logic            core_pc_we,
    input  logic [15:0]     core_pc_d,
    input  logic            core_flg_we,
    input  logic [7:0]      core_flg_d,
    output logic            stk_we,
    output logic [SP_W-1:0] stk_addr,
    output logic [7:0]      stk_wdata,
    input  logic [7:0]      stk_rdata,
    output logic [SP_W-1:0] sp,
    output logic [15:0]     pc,
    output logic [7:0]      flags,
    output logic            busy,
    output logic            done
);

    logic     push_en, pop_en, clr_flags, vec_load;
    ids_sel_e push_sel, pop_sel;

    ids_fsm #(
        .DISP_CYCLES (DISP_CYCLES),
        .RET_CYCLES  (RET_CYCLES)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .reti_req  (reti_req),
        .gie       (flags[0]),
        .busy      (busy),
        .done      (done),
        .push_en   (push_en),
        .push_sel  (push_sel),
        .clr_flags (clr_flags),
        .vec_load  (vec_load),
        .pop_en    (pop_en),
        .pop_sel   (pop_sel)
    );

    ids_regs #(
        .SP_W (SP_W)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .push_en     (push_en),
        .push_sel    (push_sel),
        .pop_en      (pop_en),
        .pop_sel     (pop_sel),
        .clr_flags   (clr_flags),
        .vec_load    (vec_load),
        .irq_vec     (irq_vec),
        .core_pc_we  (core_pc_we),
        .core_pc_d   (core_pc_d),
        .core_flg_we (core_flg_we),
        .core_flg_d  (core_flg_d),
        .stk_rdata   (stk_rdata),
        .stk_we      (stk_we),
        .stk_addr    (stk_addr),
        .stk_wdata   (stk_wdata),
        .sp          (sp),
        .pc          (pc),
        .flags       (flags)
    );

    assign irq_ack = vec_load;

    // R4: flags are already cleared when the vector is taken
    a_r4_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> flags == 8'h00);

    // R5: the PC points into the vector page after the acknowledge
    a_r5_vector_pc: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> pc == {8'h00, $past(irq_vec)});

endmodule

// File: tb/irq_dispatch_seq_tb_top.sv
`timescale 1ns/1ps
module irq_dispatch_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_done = 1'b0, reti_req = 1'b0, irq_req = 1'b0;
    logic [7:0]  irq_vec = 8'h00;
    logic        irq_ack;
    logic        core_pc_we = 1'b0, core_flg_we = 1'b0;
    logic [15:0] core_pc_d = 16'h0000;
    logic [7:0]  core_flg_d = 8'h00;
    logic        stk_we;
    logic [7:0]  stk_addr, stk_wdata, stk_rdata;
    logic [7:0]  sp;
    logic [15:0] pc;
    logic [7:0]  flags;
    logic        busy, done;

    always #2.5 clk = ~clk;

    irq_dispatch_seq dut_i (
        .clk (clk), .rst_n (rst_n), .insn_done (insn_done), .reti_req (reti_req),
        .irq_req (irq_req), .irq_vec (irq_vec), .irq_ack (irq_ack),
        .core_pc_we (core_pc_we), .core_pc_d (core_pc_d),
        .core_flg_we (core_flg_we), .core_flg_d (core_flg_d),
        .stk_we (stk_we), .stk_addr (stk_addr), .stk_wdata (stk_wdata),
        .stk_rdata (stk_rdata), .sp (sp), .pc (pc), .flags (flags),
        .busy (busy), .done (done)
    );

    logic [7:0] mem [256];
    assign stk_rdata = mem[stk_addr];
    always @(posedge clk) if (stk_we) mem[stk_addr] <= stk_wdata;

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
    wr_t exp_q[$];

    int busy_n, ack_n, done_n, done_last;

    // monitor: counts strobes and scores every stack write
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_n++;
            if (irq_ack) ack_n++;
            if (done) begin
                done_n++;
                done_last = busy_n;
            end
            if (stk_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected stack write", {stk_addr, stk_wdata}, 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    check(stk_addr == e.a && stk_wdata == e.d, "R3", "stack write {addr,data}",
                          {stk_addr, stk_wdata}, e);
                end
            end
        end
    end

    task automatic expect_push(input logic [7:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic core_load(input logic [15:0] pv, input logic [7:0] fv);
        @(negedge clk);
        core_pc_we = 1'b1; core_pc_d = pv;
        core_flg_we = 1'b1; core_flg_d = fv;
        @(negedge clk);
        core_pc_we = 1'b0; core_flg_we = 1'b0;
    endtask

    task automatic run_seq(input bit irq, input bit reti, input logic [7:0] vec, input bit junk);
        int n;
        @(negedge clk);
        busy_n = 0; ack_n = 0; done_n = 0; done_last = 0;
        insn_done = 1'b1; irq_req = irq; reti_req = reti; irq_vec = vec;
        @(negedge clk);
        insn_done = 1'b0; reti_req = 1'b0;
        n = 0;
        while (busy) begin
            if (irq_ack) irq_req = 1'b0;
            if (junk && n == 6) begin
                core_pc_we = 1'b1; core_pc_d = 16'hBEEF;
                core_flg_we = 1'b1; core_flg_d = 8'hFF;
            end else begin
                core_pc_we = 1'b0; core_flg_we = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        core_pc_we = 1'b0; core_flg_we = 1'b0; irq_req = 1'b0;
    endtask

    task automatic check_end(input string req, input int bn, input int dn, input int an,
                             input logic [15:0] epc, input logic [7:0] efl, input logic [7:0] esp);
        check(busy_n == bn, req, "busy cycles", busy_n, bn);
        check(done_n == dn, req, "done pulses", done_n, dn);
        if (dn > 0) check(done_last == bn, req, "done position", done_last, bn);
        check(ack_n == an, "R5", "ack pulses", ack_n, an);
        check(pc == epc, req, "pc", pc, epc);
        check(flags == efl, req, "flags", flags, efl);
        check(sp == esp, req, "sp", sp, esp);
        check(exp_q.size() == 0, "R3", "missing stack writes", exp_q.size(), 0);
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(pc == 16'h0000, "R10", "reset pc", pc, 0);
        check(flags == 8'h00, "R10", "reset flags", flags, 0);
        check(sp == 8'h00, "R10", "reset sp", sp, 0);
        check(busy == 1'b0 && done == 1'b0 && irq_ack == 1'b0, "R10", "reset strobes",
              {busy, done, irq_ack}, 0);

        // R8: core loads while idle
        core_load(16'h1234, 8'h81);
        check(pc == 16'h1234, "R8", "idle pc load", pc, 16'h1234);
        check(flags == 8'h81, "R8", "idle flag load", flags, 8'h81);

        // R1: request without boundary strobe
        irq_req = 1'b1; irq_vec = 8'h44;
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1", "no start without boundary", busy, 0);
        irq_req = 1'b0;

        // R1: boundary with the enable clear
        core_load(16'h1234, 8'h80);
        run_seq(1'b1, 1'b0, 8'h44, 1'b0);
        check(busy_n == 0, "R1", "no start with enable clear", busy_n, 0);
        check(pc == 16'h1234, "R1", "pc untouched", pc, 16'h1234);
        core_load(16'h1234, 8'h81);

        // R2 R3 R4 R5 R8: first dispatch with core writes attempted while busy
        expect_push(8'h00, 8'h12); expect_push(8'h01, 8'h34); expect_push(8'h02, 8'h81);
        run_seq(1'b1, 1'b0, 8'h0C, 1'b1);
        check_end("R2", 13, 1, 1, 16'h000C, 8'h00, 8'h03);
        check(flags == 8'h00, "R4", "flags after dispatch", flags, 0);
        check(pc == 16'h000C, "R8", "busy write ignored", pc, 16'h000C);

        // R3: nested dispatch from a non-zero pointer
        core_load(16'h00C5, 8'h01);
        expect_push(8'h03, 8'h00); expect_push(8'h04, 8'hC5); expect_push(8'h05, 8'h01);
        run_seq(1'b1, 1'b0, 8'h08, 1'b0);
        check_end("R3", 13, 1, 1, 16'h0008, 8'h00, 8'h06);

        // R6: return from the nested level
        run_seq(1'b0, 1'b1, 8'h00, 1'b0);
        check_end("R6", 8, 1, 0, 16'h00C5, 8'h01, 8'h03);

        // R7: return with a waiting request chains a dispatch (enable clear at boundary)
        core_load(16'h00C5, 8'h00);
        expect_push(8'h00, 8'h12); expect_push(8'h01, 8'h34); expect_push(8'h02, 8'h81);
        run_seq(1'b1, 1'b1, 8'h10, 1'b0);
        check_end("R7", 21, 2, 1, 16'h0010, 8'h00, 8'h03);

        // R9: request and return at one boundary with the enable set
        core_load(16'h0010, 8'h01);
        expect_push(8'h03, 8'h00); expect_push(8'h04, 8'h10); expect_push(8'h05, 8'h01);
        run_seq(1'b1, 1'b1, 8'h20, 1'b0);
        check_end("R9", 13, 1, 1, 16'h0020, 8'h00, 8'h06);

        // R6: plain return with no request
        run_seq(1'b0, 1'b1, 8'h00, 1'b0);
        check_end("R6", 8, 1, 0, 16'h0010, 8'h01, 8'h03);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule